// File: doc/BRIEF.md
# RAM Pattern Test Engine

This engine tests a RAM that is addressed by track, sector and byte. It runs a sequence of writes and reads over every location. It stops at the first location whose read-back differs from the value written, and it holds the address and both data bytes of that location for the host to read. The host selects a mode and pulses `start`. It then watches `busy`, `done` and `error`.

The fixed mode runs a list of twelve byte patterns. Each pattern covers every location before the next one begins. At each location the engine writes the pattern, reads it back and compares. The rolling mode writes the whole memory with a decimal (BCD) count that goes up by one per address. It then reads the whole memory back and compares. Each new pass starts the count one higher. A fault where two addresses reach the same cell leaves a later count in the shared cell, so the verify phase sees a wrong value. The fixed mode cannot see this fault, because it writes the same byte to every address.

Top module: `ramPatternEngine`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `memWe` and `memRe` are low and all error capture outputs are zero.
- R2: Fixed mode (`modeRolling`=0) applies the patterns 0x00, 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x40, 0x80, 0xFF, 0xAA, 0x55 in that order. Each pattern is written to every location before the next pattern starts.
- R3: `memAddr` is {track, sector, byte}. The byte field advances first. Sector advances when byte wraps to zero, and track advances when both wrap. In fixed mode the next pattern starts when all three wrap.
- R4: In fixed mode each write is followed in the next cycle by a read of the same address. The compare uses `memRdata` one cycle after the read. `memWe` and `memRe` are never high together.
- R5: On a mismatch, `error` goes high and `errTrack`, `errSector`, `errByte`, `errExpected` and `errActual` hold the failing location and data. No further memory write or read takes place.
- R6: When every pattern (fixed mode) or every pass (rolling mode) completes with no mismatch, `done` goes high and `busy` goes low. `done` and `error` are never high together.
- R7: Rolling mode (`modeRolling`=1) first writes every location in address order. Location i gets seed+i as a BCD count. The engine then reads and compares every location in address order against the same values.
- R8: The BCD count is two digits. The low digit carries to the high digit after 9, and 0x99 wraps to 0x00.
- R9: Rolling mode runs ROLL_PASSES passes. The first pass uses seed SEED, and each later pass uses the previous seed plus one in BCD.
- R10: A `start` pulse while `busy` is high is ignored. A `start` pulse while idle, done or in error clears `done`, `error` and the capture outputs, and begins a new run in the mode then on `modeRolling`.
- R11: In rolling mode, a RAM that drops one address bit is reported at address 0. The reported expected value is the seed, and the reported actual value is the count written to the aliased upper address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (one-cycle pulse) |
| modeRolling | input | 1 | 0 = fixed pattern list, 1 = rolling BCD count |
| memAddr | output | TRACK_W+SECTOR_W+BYTE_W | RAM address {track, sector, byte} |
| memWe | output | 1 | RAM write strobe |
| memRe | output | 1 | RAM read strobe; data is expected one cycle later |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data from the RAM |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished with no mismatch |
| error | output | 1 | Mismatch found; run halted |
| errTrack | output | TRACK_W | Track of failing location |
| errSector | output | SECTOR_W | Sector of failing location |
| errByte | output | BYTE_W | Byte index of failing location |
| errExpected | output | 8 | Value that was written |
| errActual | output | 8 | Value that was read back |

## Verification
The hardest case to reach from the ports is an address-aliasing fault. A correct RAM never produces one, and the fixed mode passes straight over it. The bench gives the RAM model selectable faults: one that ignores the top address bit, and one that holds a single data bit stuck high at one address. It runs both modes against each fault. A small geometry of 16 locations, with a seed near 99, lets every write in every pass be checked against arithmetic in the bench. It also makes the BCD wrap occur inside the first pass.

// File: rtl/ramPatternPkg.sv
package ramPatternPkg;

  localparam int DATA_W = 8;
  localparam int NUM_PATTERNS = 12;

  typedef struct packed {
    logic init;
    logic addrInc;
    logic patNext;
    logic rollInc;
    logic rollRestart;
    logic nextPass;
    logic cmpEn;
    logic wrEn;
    logic rdEn;
  } ctrlStrobes_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WR, ST_RD, ST_CMP, ST_FILL, ST_VRD, ST_VCMP, ST_DONE, ST_ERR
  } engState_t;

  function automatic logic [DATA_W-1:0] bcdInc(input logic [DATA_W-1:0] v);
    logic [3:0] lo;
    logic [3:0] hi;
    lo = v[3:0];
    hi = v[7:4];
    if (lo == 4'd9) begin
      lo = 4'd0;
      hi = (hi == 4'd9) ? 4'd0 : hi + 4'd1;
    end else begin
      lo = lo + 4'd1;
    end
    return {hi, lo};
  endfunction

  function automatic logic [DATA_W-1:0] fixedPattern(input logic [3:0] idx);
    logic [DATA_W-1:0] p;
    if (idx == 4'd0) p = 8'h00;
    else if (idx <= 4'd8) p = 8'h01 << (idx - 4'd1);
    else if (idx == 4'd9) p = 8'hFF;
    else if (idx == 4'd10) p = 8'hAA;
    else p = 8'h55;
    return p;
  endfunction

endpackage

// File: rtl/ramPatternDatapath.sv
module ramPatternDatapath
  import ramPatternPkg::*;
#(
  parameter int TRACK_W = 2,
  parameter int SECTOR_W = 4,
  parameter int BYTE_W = 7,
  parameter int ROLL_PASSES = 4,
  parameter logic [7:0] SEED = 8'h00
) (
  input  logic clk,
  input  logic rstN,
  input  ctrlStrobes_t strobes,
  input  logic rollMode,
  input  logic [DATA_W-1:0] memRdata,
  output logic [TRACK_W+SECTOR_W+BYTE_W-1:0] addr,
  output logic [DATA_W-1:0] expected,
  output logic addrLast,
  output logic patLast,
  output logic passLast,
  output logic mismatch,
  output logic errFlag,
  output logic [TRACK_W-1:0] errTrack,
  output logic [SECTOR_W-1:0] errSector,
  output logic [BYTE_W-1:0] errByte,
  output logic [DATA_W-1:0] errExpected,
  output logic [DATA_W-1:0] errActual
);

  localparam int ADDR_W = TRACK_W + SECTOR_W + BYTE_W;
  localparam int PASS_W = (ROLL_PASSES > 1) ? $clog2(ROLL_PASSES) : 1;

  logic [3:0] patIdx;
  logic [DATA_W-1:0] seed;
  logic [DATA_W-1:0] rollVal;
  logic [PASS_W-1:0] passCnt;

  assign expected = rollMode ? rollVal : fixedPattern(patIdx);
  assign addrLast = &addr;
  assign patLast = (patIdx == 4'(NUM_PATTERNS - 1));
  assign passLast = (passCnt == PASS_W'(ROLL_PASSES - 1));
  assign mismatch = (memRdata != expected);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.init) begin
      addr <= '0;
      patIdx <= '0;
      seed <= SEED;
      rollVal <= SEED;
      passCnt <= '0;
      errFlag <= 1'b0;
      errTrack <= '0;
      errSector <= '0;
      errByte <= '0;
      errExpected <= '0;
      errActual <= '0;
    end else begin
      if (strobes.addrInc) addr <= addr + ADDR_W'(1);
      if (strobes.patNext) patIdx <= patIdx + 4'd1;
      if (strobes.nextPass) begin
        seed <= bcdInc(seed);
        rollVal <= bcdInc(seed);
        passCnt <= passCnt + PASS_W'(1);
      end else if (strobes.rollRestart) begin
        rollVal <= seed;
      end else if (strobes.rollInc) begin
        rollVal <= bcdInc(rollVal);
      end
      if (strobes.cmpEn && mismatch) begin
        errFlag <= 1'b1;
        errTrack <= addr[ADDR_W-1 -: TRACK_W];
        errSector <= addr[BYTE_W +: SECTOR_W];
        errByte <= addr[BYTE_W-1:0];
        errExpected <= expected;
        errActual <= memRdata;
      end
    end
  end

  AST_HALT_ON_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !strobes.init) |-> (!strobes.wrEn && !strobes.rdEn)); // R5
  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rstN)
    (rollVal[3:0] <= 4'd9) && (rollVal[7:4] <= 4'd9)); // R8
  AST_SEED_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.nextPass && !strobes.init) |=> (rollVal == bcdInc($past(seed)))); // R9

endmodule

// File: rtl/ramPatternCtrl.sv
module ramPatternCtrl
  import ramPatternPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic modeRolling,
  input  logic addrLast,
  input  logic patLast,
  input  logic passLast,
  input  logic mismatch,
  output ctrlStrobes_t strobes,
  output logic rollMode,
  output logic busy,
  output logic done
);

  engState_t state;
  engState_t nextState;

  always_comb begin
    strobes = '0;
    nextState = state;
    case (state)
      ST_IDLE, ST_DONE, ST_ERR: begin
        if (start) begin
          strobes.init = 1'b1;
          nextState = modeRolling ? ST_FILL : ST_WR;
        end
      end
      ST_WR: begin
        strobes.wrEn = 1'b1;
        nextState = ST_RD;
      end
      ST_RD: begin
        strobes.rdEn = 1'b1;
        nextState = ST_CMP;
      end
      ST_CMP: begin
        strobes.cmpEn = 1'b1;
        if (mismatch) begin
          nextState = ST_ERR;
        end else if (addrLast && patLast) begin
          nextState = ST_DONE;
        end else begin
          strobes.addrInc = 1'b1;
          strobes.patNext = addrLast;
          nextState = ST_WR;
        end
      end
      ST_FILL: begin
        strobes.wrEn = 1'b1;
        strobes.addrInc = 1'b1;
        if (addrLast) begin
          strobes.rollRestart = 1'b1;
          nextState = ST_VRD;
        end else begin
          strobes.rollInc = 1'b1;
        end
      end
      ST_VRD: begin
        strobes.rdEn = 1'b1;
        nextState = ST_VCMP;
      end
      ST_VCMP: begin
        strobes.cmpEn = 1'b1;
        if (mismatch) begin
          nextState = ST_ERR;
        end else if (addrLast && passLast) begin
          nextState = ST_DONE;
        end else begin
          strobes.addrInc = 1'b1;
          if (addrLast) begin
            strobes.nextPass = 1'b1;
            nextState = ST_FILL;
          end else begin
            strobes.rollInc = 1'b1;
            nextState = ST_VRD;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rollMode <= 1'b0;
    end else begin
      state <= nextState;
      if (strobes.init) rollMode <= modeRolling;
    end
  end

  assign busy = (state != ST_IDLE) && (state != ST_DONE) && (state != ST_ERR);
  assign done = (state == ST_DONE);

  AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEn && !rollMode) |=> strobes.rdEn); // R4
  AST_READ_THEN_CMP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdEn |=> strobes.cmpEn); // R4
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.init); // R10

endmodule

// File: rtl/ramPatternEngine.sv
module ramPatternEngine
  import ramPatternPkg::*;
#(
  parameter int TRACK_W = 2,
  parameter int SECTOR_W = 4,
  parameter int BYTE_W = 7,
  parameter int ROLL_PASSES = 4,
  parameter logic [7:0] SEED = 8'h00
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic modeRolling,
  output logic [TRACK_W+SECTOR_W+BYTE_W-1:0] memAddr,
  output logic memWe,
  output logic memRe,
  output logic [7:0] memWdata,
  input  logic [7:0] memRdata,
  output logic busy,
  output logic done,
  output logic error,
  output logic [TRACK_W-1:0] errTrack,
  output logic [SECTOR_W-1:0] errSector,
  output logic [BYTE_W-1:0] errByte,
  output logic [7:0] errExpected,
  output logic [7:0] errActual
);

  ctrlStrobes_t strobes;
  logic rollMode;
  logic addrLast;
  logic patLast;
  logic passLast;
  logic mismatch;

  ramPatternCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modeRolling(modeRolling),
    .addrLast(addrLast), .patLast(patLast), .passLast(passLast),
    .mismatch(mismatch), .strobes(strobes), .rollMode(rollMode),
    .busy(busy), .done(done)
  );

  ramPatternDatapath #(
    .TRACK_W(TRACK_W), .SECTOR_W(SECTOR_W), .BYTE_W(BYTE_W),
    .ROLL_PASSES(ROLL_PASSES), .SEED(SEED)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rollMode(rollMode),
    .memRdata(memRdata), .addr(memAddr), .expected(memWdata),
    .addrLast(addrLast), .patLast(patLast), .passLast(passLast),
    .mismatch(mismatch), .errFlag(error), .errTrack(errTrack),
    .errSector(errSector), .errByte(errByte), .errExpected(errExpected),
    .errActual(errActual)
  );

  assign memWe = strobes.wrEn;
  assign memRe = strobes.rdEn;

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe)); // R4
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error)); // R6
  AST_ERROR_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (error && !busy && !start) |=> (!memWe && !memRe)); // R5

endmodule

// File: tb/ramPatternEngine_bench.sv
module ramPatternEngine_bench;

  localparam int TW = 1;
  localparam int SW = 1;
  localparam int BW = 2;
  localparam int AW = TW + SW + BW;
  localparam int NLOC = 1 << AW;
  localparam int PASSES = 3;
  localparam logic [7:0] SEED = 8'h95;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic modeRolling = 1'b0;
  logic [AW-1:0] memAddr;
  logic memWe;
  logic memRe;
  logic [7:0] memWdata;
  logic [7:0] memRdata;
  logic busy;
  logic done;
  logic error;
  logic [TW-1:0] errTrack;
  logic [SW-1:0] errSector;
  logic [BW-1:0] errByte;
  logic [7:0] errExpected;
  logic [7:0] errActual;

  int checks = 0;
  int fails = 0;
  int faultMode = 0;
  int wrCount = 0;
  int cycles = 0;
  logic expRolling = 1'b0;
  logic [7:0] ram [NLOC];

  always #4 clk = ~clk;

  ramPatternEngine #(
    .TRACK_W(TW), .SECTOR_W(SW), .BYTE_W(BW),
    .ROLL_PASSES(PASSES), .SEED(SEED)
  ) u_ramPatternEngine (
    .clk(clk), .rstN(rstN), .start(start), .modeRolling(modeRolling),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe), .memWdata(memWdata),
    .memRdata(memRdata), .busy(busy), .done(done), .error(error),
    .errTrack(errTrack), .errSector(errSector), .errByte(errByte),
    .errExpected(errExpected), .errActual(errActual)
  );

  function automatic int mapAddr(input int a);
    return (faultMode == 2) ? (a & (NLOC / 2 - 1)) : a;
  endfunction

  always @(posedge clk) begin
    if (memWe) ram[mapAddr(int'(memAddr))] <=
      (faultMode == 1 && memAddr == AW'(5)) ? (memWdata | 8'h08) : memWdata;
    if (memRe) memRdata <= ram[mapAddr(int'(memAddr))];
  end

  function automatic int fromBcd(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] toBcd(input int n);
    int m;
    m = n % 100;
    return {4'(m / 10), 4'(m % 10)};
  endfunction

  function automatic logic [7:0] patOf(input int i);
    if (i == 0) return 8'h00;
    if (i <= 8) return 8'(1 << (i - 1));
    if (i == 9) return 8'hFF;
    if (i == 10) return 8'hAA;
    return 8'h55;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Write-stream monitor: every write is compared with the arithmetic model (R2 R3 R7 R8 R9)
  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (expRolling) begin
        check("R7 addr", 32'(memAddr), 32'(wrCount % NLOC));
        check("R8 R9 data", 32'(memWdata),
              32'(toBcd(fromBcd(SEED) + wrCount / NLOC + wrCount % NLOC)));
      end else begin
        check("R3 addr", 32'(memAddr), 32'(wrCount % NLOC));
        check("R2 data", 32'(memWdata), 32'(patOf(wrCount / NLOC)));
      end
      wrCount++;
    end
  end

  task automatic launch(input logic rolling, input int fault);
    @(negedge clk);
    faultMode = fault;
    modeRolling = rolling;
    expRolling = rolling;
    wrCount = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitEnd();
    int n;
    n = 0;
    while (!done && !error && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) check("watchdog", 32'd1, 32'd0);
  endtask

  initial begin
    int hold;
    repeat (3) @(negedge clk);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 error", 32'(error), 32'd0);
    check("R1 we/re", 32'({memWe, memRe}), 32'd0);
    check("R1 capture", 32'({errExpected, errActual}), 32'd0);
    rstN = 1'b1;

    // Fixed mode on a good RAM
    launch(1'b0, 0);
    check("R10 busy after start", 32'(busy), 32'd1);
    waitEnd();
    check("R6 done fixed", 32'(done), 32'd1);
    check("R6 no error", 32'(error), 32'd0);
    check("R2 write count", 32'(wrCount), 32'(12 * NLOC));

    // Rolling mode on a good RAM, with a start pulse mid-run that must be ignored
    launch(1'b1, 0);
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitEnd();
    check("R10 ignored start", 32'(wrCount), 32'(PASSES * NLOC));
    check("R9 done rolling", 32'(done), 32'd1);

    // Stuck data bit at address 5, fixed mode
    launch(1'b0, 1);
    waitEnd();
    check("R5 error", 32'(error), 32'd1);
    check("R6 not done", 32'(done), 32'd0);
    check("R5 track", 32'(errTrack), 32'd0);
    check("R5 sector", 32'(errSector), 32'd1);
    check("R5 byte", 32'(errByte), 32'd1);
    check("R5 expected", 32'(errExpected), 32'h00);
    check("R5 actual", 32'(errActual), 32'h08);
    check("R4 writes before stop", 32'(wrCount), 32'd6);
    hold = wrCount;
    repeat (20) @(negedge clk);
    check("R5 halted", 32'(wrCount), 32'(hold));
    check("R5 no access", 32'({memWe, memRe}), 32'd0);

    // Aliased address bit: fixed mode misses it
    launch(1'b0, 2);
    check("R10 flags cleared", 32'({error, errActual}), 32'd0);
    waitEnd();
    check("R11 fixed blind", 32'({done, error}), 32'b10);

    // Aliased address bit: rolling mode reports it
    launch(1'b1, 2);
    waitEnd();
    check("R11 error", 32'(error), 32'd1);
    check("R11 fill complete", 32'(wrCount), 32'(NLOC));
    check("R11 location", 32'({errTrack, errSector, errByte}), 32'd0);
    check("R11 expected", 32'(errExpected), 32'(SEED));
    check("R11 actual", 32'(errActual), 32'(toBcd(fromBcd(SEED) + NLOC / 2)));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule